// File: doc/BRIEF.md
# Variable-Latency Ripple Adder with Slow-Carry Prediction

This block adds two unsigned operands and a carry-in through a ripple-carry chain, but it does not give every operation the same time. Before the addition is taken, it forms per-bit propagate and generate terms and checks whether the operation will drive a carry along the entire chain, from carry-in to carry-out. That full-length ripple is the slowest path in the adder. It occurs only when the carry-in is 1 and every propagate bit is 1. When it occurs, the result is captured one cycle later than usual. All other operations finish in one cycle.

The controller is a two-state machine. `ST_READY` accepts an operation whenever `in_valid` is high. A fast operation registers its result on the accepting edge and stays in `ST_READY`. A slow operation stores its operands on that edge and moves `ST_READY -> ST_EXTEND`. In `ST_EXTEND`, `busy` is high and `in_valid` is ignored. The next edge registers the result from the stored operands and takes the transition `ST_EXTEND -> ST_READY`, which is unconditional. The slow path is modelled behaviourally, as a result captured one cycle late. No real gate delay is modelled.

Top module: `vlat_adder`

## Requirements
- R1: Every result satisfies {carry_out, sum_out} == op_a + op_b + carry_in, computed at WIDTH+1 bits from the operands of the accepted operation.
- R2: An accepted operation is slow when carry_in is 1 and every bit of the propagate vector (op_a XOR op_b) is 1. Otherwise it is fast.
- R3: A fast operation accepted on clock edge E pulses out_valid high for the one cycle after E, and busy stays low.
- R4: A slow operation accepted on edge E raises busy for exactly the cycle after E, with out_valid low. The result then appears with out_valid high for the cycle after edge E+1.
- R5: in_valid is ignored while busy is high. No additional result is produced, and the pending slow result is not altered.
- R6: A synchronous active-high rst clears out_valid, busy, sum_out and carry_out on the next edge. This includes the case where a slow operation is pending.
- R7: out_valid is high for exactly one cycle per accepted operation. Back-to-back fast operations each produce their own pulse, in order.
- R8: Inputs whose propagate bits are all 1 but whose carry_in is 0, and inputs that generate a carry without propagating it, are fast.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered this cycle |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Registered sum |
| carry_out | output | 1 | Registered carry out of the top bit |
| out_valid | output | 1 | One-cycle pulse when sum_out/carry_out hold a new result |
| busy | output | 1 | High during the extra cycle of a slow operation |

## Verification
The properties take for granted that the operands and carry-in are steady and defined on every edge where in_valid is high. The sum properties compare against the operands sampled on the accepting edge. They do not use the values offered while busy, so an operand change during the extra cycle must not leak into the result. The stimulus changes its inputs only on falling edges. It covers every operand pair for both carry-in values, which reaches the slow condition and both of its near misses. During some extra cycles it deliberately offers a different operation, to show that the offer is dropped.

// File: rtl/vlat_pkg.sv
package vlat_pkg;

    typedef enum logic [0:0] {
        ST_READY  = 1'b0,
        ST_EXTEND = 1'b1
    } vlat_state_e;

endpackage

// File: rtl/vlat_pg_unit.sv
module vlat_pg_unit #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] opnd_x,
    input  logic [WIDTH-1:0] opnd_y,
    output logic [WIDTH-1:0] prop,
    output logic [WIDTH-1:0] gen
);

    // Per-bit propagate and generate terms
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign prop[i] = opnd_x[i] ^ opnd_y[i];
        assign gen[i]  = opnd_x[i] & opnd_y[i];
    end

endmodule

// File: rtl/vlat_slow_predict.sv
module vlat_slow_predict #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] prop,
    input  logic             cin,
    output logic             slow_path
);

    // Running AND along the chain; the last stage says the carry crosses all bits
    logic [WIDTH:0] run_and;

    assign run_and[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        assign run_and[i+1] = run_and[i] & prop[i];
    end

    assign slow_path = run_and[WIDTH];

endmodule

// File: rtl/vlat_ripple.sv
module vlat_ripple #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] prop,
    input  logic [WIDTH-1:0] gen,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    logic [WIDTH:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        assign carry[i+1] = gen[i] | (prop[i] & carry[i]);
        assign sum[i]     = prop[i] ^ carry[i];
    end

    assign cout = carry[WIDTH];

endmodule

// File: rtl/vlat_adder.sv
module vlat_adder
    import vlat_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             out_valid,
    output logic             busy
);

    vlat_state_e state_q;
    vlat_state_e state_d;

    logic [WIDTH-1:0] held_a;
    logic [WIDTH-1:0] held_b;
    logic             held_c;

    logic [WIDTH-1:0] sel_a;
    logic [WIDTH-1:0] sel_b;
    logic             sel_c;

    logic [WIDTH-1:0] prop;
    logic [WIDTH-1:0] gen;
    logic             slow_path;
    logic [WIDTH-1:0] raw_sum;
    logic             raw_cout;
    logic             accept;

    // In the extra cycle the chain is fed from the stored operands
    assign sel_a = (state_q == ST_EXTEND) ? held_a : op_a;
    assign sel_b = (state_q == ST_EXTEND) ? held_b : op_b;
    assign sel_c = (state_q == ST_EXTEND) ? held_c : carry_in;

    assign accept = in_valid && (state_q == ST_READY);
    assign busy   = (state_q == ST_EXTEND);

    vlat_pg_unit #(.WIDTH(WIDTH)) u_pg (
        .opnd_x (sel_a),
        .opnd_y (sel_b),
        .prop   (prop),
        .gen    (gen)
    );

    vlat_slow_predict #(.WIDTH(WIDTH)) u_predict (
        .prop      (prop),
        .cin       (sel_c),
        .slow_path (slow_path)
    );

    vlat_ripple #(.WIDTH(WIDTH)) u_chain (
        .prop (prop),
        .gen  (gen),
        .cin  (sel_c),
        .sum  (raw_sum),
        .cout (raw_cout)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: begin
                if (accept && slow_path) begin
                    state_d = ST_EXTEND;
                end
            end
            ST_EXTEND: begin
                state_d = ST_READY;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_READY;
        end else begin
            state_q <= state_d;
        end
    end

    // Result and operand registers
    always_ff @(posedge clk) begin
        if (rst) begin
            sum_out   <= '0;
            carry_out <= 1'b0;
            out_valid <= 1'b0;
            held_a    <= '0;
            held_b    <= '0;
            held_c    <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            unique case (state_q)
                ST_READY: begin
                    if (accept && !slow_path) begin
                        sum_out   <= raw_sum;
                        carry_out <= raw_cout;
                        out_valid <= 1'b1;
                    end else if (accept) begin
                        held_a <= op_a;
                        held_b <= op_b;
                        held_c <= carry_in;
                    end
                end
                ST_EXTEND: begin
                    sum_out   <= raw_sum;
                    carry_out <= raw_cout;
                    out_valid <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/vlat_adder_chk.sv
module vlat_adder_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum_out,
    input logic             carry_out,
    input logic             out_valid,
    input logic             busy
);

    logic [WIDTH:0] ref_total;
    logic           ref_slow;
    logic           take;

    assign ref_total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
    assign ref_slow  = carry_in && ((op_a ^ op_b) == {WIDTH{1'b1}});
    assign take      = in_valid && !busy;

    // R3: fast accept yields a result next cycle, not busy
    a_r3_fast_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (take && !ref_slow) |=> (out_valid && !busy));

    // R2, R4: slow accept enters the extra cycle with no result yet
    a_r4_slow_enters_busy: assert property (@(posedge clk) disable iff (rst)
        (take && ref_slow) |=> (busy && !out_valid));

    // R4: busy lasts one cycle and ends with the result
    a_r4_busy_single: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy && out_valid));

    // R1: fast result value
    a_r1_fast_sum: assert property (@(posedge clk) disable iff (rst)
        (take && !ref_slow) |=> ({carry_out, sum_out} == $past(ref_total)));

    // R1, R5: slow result uses operands from the accepting edge
    a_r1_slow_sum: assert property (@(posedge clk) disable iff (rst)
        busy |=> ({carry_out, sum_out} == $past(ref_total, 2)));

    // R7: no result without an accepted operation behind it
    a_r7_valid_has_source: assert property (@(posedge clk) disable iff (rst)
        (!take && !busy) |=> !out_valid);

    // R6: reset clears the handshake outputs
    a_r6_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && !busy && (sum_out == '0) && !carry_out));

endmodule

bind vlat_adder vlat_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .out_valid (out_valid),
    .busy      (busy)
);

// File: tb/vlat_adder_bench.sv
module vlat_adder_bench;

    localparam int WIDTH = 4;
    localparam int TOPV  = (1 << WIDTH);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [WIDTH-1:0] op_a = '0;
    logic [WIDTH-1:0] op_b = '0;
    logic             carry_in = 1'b0;
    logic [WIDTH-1:0] sum_out;
    logic             carry_out;
    logic             out_valid;
    logic             busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [WIDTH:0] total;
        int             due;
        string          tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    vlat_adder #(.WIDTH(WIDTH)) u_vlat_adder (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out),
        .out_valid (out_valid),
        .busy      (busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, expv, cyc);
        end
    endtask

    // Monitor: pops the scoreboard whenever a result appears
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R5/R7 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({carry_out, sum_out} == e.total, {"R1 ", e.tag}, int'({carry_out, sum_out}), int'(e.total));
                check(cyc == e.due, {"R3/R4 latency ", e.tag}, cyc, e.due);
            end
        end
    end

    // Driver: offers one operation, optionally pokes in_valid during the extra cycle
    task automatic issue(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                         input logic c, input bit poke);
        exp_t e;
        bit   slow;
        slow    = c && ((a ^ b) == {WIDTH{1'b1}});
        e.total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, c};
        e.due   = cyc + (slow ? 2 : 1);
        e.tag   = slow ? "R2 slow" : "R2 fast";
        sb.push_back(e);
        op_a = a; op_b = b; carry_in = c; in_valid = 1'b1;
        @(negedge clk);
        if (slow) begin
            check(busy == 1'b1, "R4 busy in extra cycle", busy, 1);
            if (poke) begin
                op_a = ~a; op_b = a; carry_in = 1'b0; in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
            in_valid = 1'b0;
            check(busy == 1'b0, "R4 busy drops", busy, 0);
        end else begin
            check(busy == 1'b0, "R3 fast never busy", busy, 0);
        end
    endtask

    task automatic finish_run();
        check(sb.size() == 0, "R7 all results delivered", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        done = 1'b1;
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R6: reset state
        check(out_valid == 1'b0, "R6 out_valid after reset", out_valid, 0);
        check(busy == 1'b0, "R6 busy after reset", busy, 0);
        check({carry_out, sum_out} == '0, "R6 result after reset", int'({carry_out, sum_out}), 0);

        // R8: near misses of the slow condition
        issue(4'hF, 4'h0, 1'b0, 1'b0);
        issue(4'hF, 4'hF, 1'b1, 1'b0);
        // R2: the slow condition itself
        issue(4'hF, 4'h0, 1'b1, 1'b0);
        // R5: offer during extra cycle is dropped
        issue(4'h5, 4'hA, 1'b1, 1'b1);
        @(negedge clk);
        check(out_valid == 1'b0, "R5 dropped offer made no result", out_valid, 0);
        // R7: back-to-back fast operations
        issue(4'h3, 4'h4, 1'b0, 1'b0);
        issue(4'h7, 4'h9, 1'b1, 1'b0);
        issue(4'h1, 4'h1, 1'b0, 1'b0);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);

        // R1: exhaustive operands, poke on alternate slow ops
        for (int c = 0; c < 2; c++) begin
            for (int a = 0; a < TOPV; a++) begin
                for (int b = 0; b < TOPV; b++) begin
                    issue(WIDTH'(a), WIDTH'(b), 1'(c), bit'(b[0]));
                end
            end
        end
        in_valid = 1'b0;
        repeat (3) @(negedge clk);

        // R6: reset while a slow operation is pending
        op_a = 4'h9; op_b = 4'h6; carry_in = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(busy == 1'b1, "R6 pending slow before reset", busy, 1);
        rst = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R6 busy cleared mid-op", busy, 0);
        check(out_valid == 1'b0, "R6 no result after reset", out_valid, 0);
        check({carry_out, sum_out} == '0, "R6 result cleared", int'({carry_out, sum_out}), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R6 aborted op stays silent", out_valid, 0);

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule